// File: doc/BRIEF.md
# Reset and Clock-Output Controller

This block sits between the chip's active-low reset pin and the rest of a USB peripheral controller that has an embedded CPU. It holds the CPU in reset while the pin is low and releases it cleanly into the clock domain. While the CPU is held, it raises a policy flag that makes the USB engine NAK every IN and OUT token. It also owns the enable for the external clock output. That enable is a single registered signal, so the external gate never sees a glitch. It combines four inputs: reset, the suspend state, wakeup events, and a firmware inhibit bit.

The suspend state is set by a suspend request. It is cleared by USB bus activity, or by a rising edge on either of two wakeup pins whose enable is set; each wakeup pin passes through a two-flop synchronizer first. The suspend state survives reset. If the pin is released while the device is suspended, the clock output stops as soon as the reset has left the clock domain. A small control register written by the CPU holds the clock-output enable and the CPU clock-speed select. Both return to their defaults on every reset.

Top module: `usb_rstclk_ctrl`

## Requirements
- R1: A low level on `rst_pin_n` raises `cpu_rst` at once, without waiting for a clock edge. After the pin returns high, `cpu_rst` stays high through the first rising clock edge and falls at the second.
- R2: `clkout_en` is 1 at every clock edge that follows an edge at which `cpu_rst` was high, whatever the suspend state or the control register hold.
- R3: If the device is suspended when reset is released, `clkout_en` stays 1 through the edge where `cpu_rst` falls and drops to 0 at the next edge.
- R4: A suspend request sampled at a clock edge, with no resume cause present, drives `clkout_en` to 0 at that same edge. While suspended, `bus_activity` sampled high drives `clkout_en` back to 1 at that edge, provided the enable bit is 1.
- R5: A rising edge on `wake_a` or `wake_b` resumes the device only if its enable input is 1. `clkout_en` rises at the third clock edge after the pin rises. With the enable at 0, the pin has no effect.
- R6: A resume cause (bus activity or a wakeup event) present in the same cycle as a suspend request wins, so `clkout_en` is 1 after that edge.
- R7: Control register bit 1 is the clock-output enable, reset value 1. A write with bit 1 = 0 drives `clkout_en` to 0 at the edge of the write. A write with bit 1 = 1 restores it if the device is not suspended.
- R8: Control register bits [4:3] drive `cpu_speed`: 00 = 12 MHz (reset value), 01 = 24 MHz, 10 = 48 MHz. A write carrying 11 leaves `cpu_speed` unchanged. Every reset returns it to 00.
- R9: Writes to the control register are ignored while `cpu_rst` is 1.
- R10: `nak_all` is 1 exactly while `cpu_rst` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_pin_n | input | 1 | Chip reset pin, active low, asynchronous |
| suspend_req | input | 1 | Request to enter suspend, sampled per cycle |
| bus_activity | input | 1 | USB bus activity seen, synchronous to clk |
| wake_a | input | 1 | Wakeup pin A, asynchronous |
| wake_a_en | input | 1 | Enable for wakeup pin A |
| wake_b | input | 1 | Wakeup pin B, asynchronous |
| wake_b_en | input | 1 | Enable for wakeup pin B |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | CTL_W | Control register write data |
| cpu_rst | output | 1 | CPU reset, active high |
| clkout_en | output | 1 | Registered enable for the external clock output |
| cpu_speed | output | 2 | CPU clock-speed select |
| nak_all | output | 1 | Tells the USB engine to NAK IN and OUT tokens |

## Verification
A vector table drives suspend requests and bus activity in sequence: lone requests, lone activity, idle cycles, and both together. This separates gating from resuming and shows that resume wins over suspend. Directed wakeup tests use each pin with its enable off and then on. The sample just before and just after the third edge pins the synchronizer latency. A suspend request is timed into the cycle of the wakeup event to test priority. Reset is exercised twice: once with a suspend and writes issued while it is held, to show the clock stays on and the writes are dropped; and once asserted in mid-cycle, to show that `cpu_rst` rises without an edge and that the speed select returns to 12 MHz.

// File: rtl/usb_rstclk_ctrl.sv
module usb_rstclk_ctrl #(
  parameter int CTL_W     = 8,
  parameter int CLKOE_BIT = 1,
  parameter int SPD_LSB   = 3
) (
  input  logic             clk,
  input  logic             rst_pin_n,
  input  logic             suspend_req,
  input  logic             bus_activity,
  input  logic             wake_a,
  input  logic             wake_a_en,
  input  logic             wake_b,
  input  logic             wake_b_en,
  input  logic             reg_wr,
  input  logic [CTL_W-1:0] reg_wdata,
  output logic             cpu_rst,
  output logic             clkout_en,
  output logic [1:0]       cpu_speed,
  output logic             nak_all
);
  localparam logic [1:0] SPD_12M      = 2'b00;
  localparam logic [1:0] SPD_RESERVED = 2'b11;
  localparam int         WSYNC        = 3;

  // reset: asynchronous assert, two-flop release
  logic [1:0] rst_sync;
  always_ff @(posedge clk or negedge rst_pin_n)
    if (!rst_pin_n) rst_sync <= 2'b11;
    else            rst_sync <= {rst_sync[0], 1'b0};

  assign cpu_rst = rst_sync[1];
  assign nak_all = rst_sync[1];

  // wakeup pins: two synchronizing flops plus one for edge detection
  logic [WSYNC-1:0] wa_s = '0;
  logic [WSYNC-1:0] wb_s = '0;
  always_ff @(posedge clk) begin
    wa_s <= {wa_s[WSYNC-2:0], wake_a};
    wb_s <= {wb_s[WSYNC-2:0], wake_b};
  end

  logic wake_evt;
  assign wake_evt = (wa_s[WSYNC-2] & ~wa_s[WSYNC-1] & wake_a_en) |
                    (wb_s[WSYNC-2] & ~wb_s[WSYNC-1] & wake_b_en);

  // suspend state, kept across reset
  logic susp_q = 1'b0;
  logic susp_d;
  assign susp_d = (wake_evt | bus_activity) ? 1'b0 :
                  suspend_req               ? 1'b1 : susp_q;
  always_ff @(posedge clk) susp_q <= susp_d;

  // control register
  logic       clkoe_q;
  logic [1:0] spd_q;
  logic       wr_ok;
  logic       clkoe_nx;
  logic [1:0] spd_wr;
  assign wr_ok    = reg_wr & ~cpu_rst;
  assign spd_wr   = reg_wdata[SPD_LSB +: 2];
  assign clkoe_nx = wr_ok ? reg_wdata[CLKOE_BIT] : clkoe_q;

  always_ff @(posedge clk or negedge rst_pin_n)
    if (!rst_pin_n) begin
      clkoe_q <= 1'b1;
      spd_q   <= SPD_12M;
    end else if (cpu_rst) begin
      clkoe_q <= 1'b1;
      spd_q   <= SPD_12M;
    end else if (reg_wr) begin
      clkoe_q <= reg_wdata[CLKOE_BIT];
      if (spd_wr != SPD_RESERVED) spd_q <= spd_wr;
    end

  assign cpu_speed = spd_q;

  // glitch-free registered clock-output enable
  logic clkout_q = 1'b1;
  always_ff @(posedge clk) clkout_q <= cpu_rst | (~susp_d & clkoe_nx);
  assign clkout_en = clkout_q;
endmodule

module usb_rstclk_ctrl_chk #(
  parameter int CTL_W     = 8,
  parameter int CLKOE_BIT = 1
) (
  input logic             clk,
  input logic             rst_pin_n,
  input logic             suspend_req,
  input logic             bus_activity,
  input logic             reg_wr,
  input logic [CTL_W-1:0] reg_wdata,
  input logic             wake_evt,
  input logic             clkoe,
  input logic             cpu_rst,
  input logic             clkout_en,
  input logic [1:0]       cpu_speed
);
  logic started = 1'b0;
  always_ff @(posedge clk) started <= 1'b1;

  AST_PIN_HOLDS_CPU: assert property (@(posedge clk) disable iff (!started)
    !rst_pin_n |-> cpu_rst); // R1
  AST_CLKOUT_IN_RESET: assert property (@(posedge clk) disable iff (!started)
    $past(cpu_rst) |-> clkout_en); // R2
  AST_SUSPEND_GATES: assert property (@(posedge clk) disable iff (!started || !rst_pin_n)
    (!cpu_rst && suspend_req && !bus_activity && !wake_evt) |=> !clkout_en); // R4
  AST_RESUME_WINS: assert property (@(posedge clk) disable iff (!started || !rst_pin_n)
    (!cpu_rst && bus_activity && clkoe && !reg_wr) |=> clkout_en); // R6
  AST_SPEED_LEGAL: assert property (@(posedge clk) disable iff (!started)
    cpu_speed != 2'b11); // R8
  AST_NO_WRITE_IN_RESET: assert property (@(posedge clk) disable iff (!started)
    cpu_rst |=> cpu_speed == 2'b00); // R9
endmodule

bind usb_rstclk_ctrl usb_rstclk_ctrl_chk #(.CTL_W(CTL_W), .CLKOE_BIT(CLKOE_BIT)) u_chk (
  .clk(clk), .rst_pin_n(rst_pin_n), .suspend_req(suspend_req), .bus_activity(bus_activity),
  .reg_wr(reg_wr), .reg_wdata(reg_wdata), .wake_evt(wake_evt), .clkoe(clkoe_q),
  .cpu_rst(cpu_rst), .clkout_en(clkout_en), .cpu_speed(cpu_speed)
);

// File: tb/usb_rstclk_ctrl_tb.sv
module usb_rstclk_ctrl_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_pin_n = 1'b0, suspend_req = 1'b0, bus_activity = 1'b0;
  logic wake_a = 1'b0, wake_a_en = 1'b0, wake_b = 1'b0, wake_b_en = 1'b0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic cpu_rst, clkout_en, nak_all;
  logic [1:0] cpu_speed;

  int checks = 0, failures = 0;

  usb_rstclk_ctrl dut_i (
    .clk(clk), .rst_pin_n(rst_pin_n), .suspend_req(suspend_req), .bus_activity(bus_activity),
    .wake_a(wake_a), .wake_a_en(wake_a_en), .wake_b(wake_b), .wake_b_en(wake_b_en),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .cpu_rst(cpu_rst), .clkout_en(clkout_en),
    .cpu_speed(cpu_speed), .nak_all(nak_all)
  );

  // {suspend_req, bus_activity, expected clkout_en}
  localparam logic [2:0] VEC [7] = '{
    3'b011, 3'b100, 3'b000, 3'b111, 3'b001, 3'b100, 3'b011
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    reg_wr = 1'b1; reg_wdata = d;
    cyc(1);
    reg_wr = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    cyc(3);
    chk("R1 reset hold", cpu_rst, 1);
    chk("R10 nak in reset", nak_all, 1);
    chk("R2 clkout in reset", clkout_en, 1);
    chk("R8 speed default", cpu_speed, 0);
    wr(8'b0000_1000);
    chk("R9 speed write ignored", cpu_speed, 0);
    chk("R9 clkoe write ignored", clkout_en, 1);
    suspend_req = 1'b1; cyc(1); suspend_req = 1'b0;
    chk("R2 suspend in reset", clkout_en, 1);
    cyc(1);
    chk("R2 still on", clkout_en, 1);
    rst_pin_n = 1'b1;
    cyc(1);
    chk("R1 release edge1", cpu_rst, 1);
    cyc(1);
    chk("R1 release edge2", cpu_rst, 0);
    chk("R10 nak off", nak_all, 0);
    chk("R3 clkout edge2", clkout_en, 1);
    cyc(1);
    chk("R3 clkout stops", clkout_en, 0);

    for (int v = 0; v < 7; v++) begin
      suspend_req = VEC[v][2]; bus_activity = VEC[v][1];
      cyc(1);
      chk(VEC[v][2] && VEC[v][1] ? "R6 vector" : "R4 vector", clkout_en, VEC[v][0]);
    end
    suspend_req = 1'b0; bus_activity = 1'b0;

    suspend_req = 1'b1; cyc(1); suspend_req = 1'b0;
    chk("R4 suspended", clkout_en, 0);
    wake_a = 1'b1; cyc(4);
    chk("R5 disabled pin", clkout_en, 0);
    wake_a = 1'b0; cyc(3);
    wake_a_en = 1'b1; wake_a = 1'b1;
    cyc(2);
    chk("R5 before third edge", clkout_en, 0);
    cyc(1);
    chk("R5 wake a", clkout_en, 1);
    wake_a = 1'b0; cyc(3);

    suspend_req = 1'b1; cyc(1); suspend_req = 1'b0;
    wake_b_en = 1'b1; wake_b = 1'b1;
    cyc(2);
    suspend_req = 1'b1; cyc(1); suspend_req = 1'b0;
    chk("R6 wake beats suspend", clkout_en, 1);
    wake_b = 1'b0; cyc(3);

    wr(8'b0000_0000);
    chk("R7 inhibit", clkout_en, 0);
    wr(8'b0001_0010);
    chk("R7 restore", clkout_en, 1);
    chk("R8 speed 48", cpu_speed, 2);
    wr(8'b0001_1010);
    chk("R8 reserved ignored", cpu_speed, 2);
    wr(8'b0000_1010);
    chk("R8 speed 24", cpu_speed, 1);

    #3 rst_pin_n = 1'b0;
    #1;
    chk("R1 async assert", cpu_rst, 1);
    chk("R10 async nak", nak_all, 1);
    chk("R8 speed reset", cpu_speed, 0);
    cyc(1);
    chk("R2 clkout after assert", clkout_en, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule